// File: doc/BRIEF.md
# Masked Level Interrupt Concentrator

The block gathers a parameterised set of level-sensitive interrupt request lines (sixteen by default) and merges them into one interrupt output for a processor. Each request line is sampled into a source register on every clock. The source register is combined with an enable mask that software can read and write. Whenever any line is both high and enabled, the interrupt output is raised.

Software reaches the block through a small 16-bit register window. The block does not return a raw bit vector of pending lines. Instead it reports which line to service: reading the source offset gives the lowest-numbered line that is both pending and enabled, encoded as (index + 1) shifted left by two. The value is zero when nothing is pending. The handler needs no acknowledge step. It silences its device, and the level falls away. After reset the enable mask holds a non-zero pattern, so one line (line 4) is armed before software has configured anything.

The interrupt output is the output of a two-state machine, QUIET and RAISED. The RAISE transition moves QUIET to RAISED when the next-cycle pending set is non-empty. The DROP transition moves RAISED to QUIET when that set is empty. In every other case the machine holds its state.

Top module: `lbint_ctrl`

## Requirements
- R1: The source register takes the level of every request line at each rising clock edge and keeps no memory of earlier levels. A line that goes low clears its bit at the next edge.
- R2: `irq_o` is high exactly when (source AND enable mask) is non-zero. It reflects a change of a request line, or a mask write, one clock after the edge at which that change is sampled.
- R3: A read at byte offset 0x00 returns zero when no line is pending and enabled. Otherwise it returns (n+1)<<2, where n is the lowest-numbered line that is pending and enabled. Line 0 reads 0x0004 and line 15 reads 0x0040.
- R4: A read at byte offset 0x02 returns the enable mask, where bit i enables line i. A write at offset 0x02 replaces the mask with `wdata`, and the new mask is visible from the next clock edge.
- R5: After reset the enable mask is 0x0010, the source register is zero, `irq_o` is low, and a read at offset 0x00 returns zero.
- R6: A write at offset 0x00 changes neither the enable mask, nor `irq_o`, nor the value read at offset 0x00.
- R7: A read at any offset other than 0x00 and 0x02 returns zero. A write at any such offset changes nothing.
- R8: A line whose mask bit is clear never raises `irq_o` and never appears in the encoded value. A masked low-numbered line does not hide an enabled higher-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 16 | Level-sensitive interrupt request lines |
| wr_en | input | 1 | Register write strobe, taken at the rising edge |
| addr | input | 12 | Byte offset into the register window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational from registered state |
| irq_o | output | 1 | Merged interrupt output |

## Verification
A corrupted source or mask register shows at the ports within one clock. `irq_o` then disagrees with the AND of the levels and the mask that were applied one edge earlier, and the encoded read at offset 0x00 names the wrong line. A wrong machine state is also visible one clock after the edge that caused it, as `irq_o` stuck on or off against the pending set. Encoder faults show only when several lines are pending together, so the stimulus mixes dense and sparse line patterns with random masks, and adds directed cases with masked low lines.

// File: rtl/lbint_pkg.sv
package lbint_pkg;

    // Interrupt output machine states
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

    // Register window byte offsets
    localparam int unsigned OFS_CODE = 0;
    localparam int unsigned OFS_MASK = 2;

endpackage

// File: rtl/lbint_src_reg.sv
module lbint_src_reg #(
    parameter int unsigned NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lines_i,
    output logic [NLINES-1:0] src_q
);

    // Pure level sampling: no latching of earlier highs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= lines_i;
        end
    end

endmodule

// File: rtl/lbint_mask_reg.sv
module lbint_mask_reg #(
    parameter int unsigned          NLINES   = 16,
    parameter logic [NLINES-1:0]    MASK_RST = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [NLINES-1:0] data_i,
    output logic [NLINES-1:0] mask_q,
    output logic [NLINES-1:0] mask_nxt
);

    always_comb begin
        mask_nxt = load_i ? data_i : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
        end else begin
            mask_q <= mask_nxt;
        end
    end

endmodule

// File: rtl/lbint_prio_enc.sv
module lbint_prio_enc #(
    parameter int unsigned NLINES = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic [NLINES-1:0] pend_i,
    output logic [DATA_W-1:0] code_o
);

    // seen[i] is high when any line below i is pending
    logic [NLINES:0]   seen;
    logic [NLINES-1:0] first;

    assign seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < NLINES; gi++) begin : g_chain
            assign first[gi]  = pend_i[gi] & ~seen[gi];
            assign seen[gi+1] = seen[gi] | pend_i[gi];
        end
    endgenerate

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (first[i]) begin
                code_o = code_o | DATA_W'((i + 1) << 2);
            end
        end
    end

endmodule

// File: rtl/lbint_irq_fsm.sv
module lbint_irq_fsm
    import lbint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend_nxt,
    output logic irq_o
);

    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_pend_nxt)  state_d = IRQ_RAISED;  // RAISE
            IRQ_RAISED: if (!any_pend_nxt) state_d = IRQ_QUIET;   // DROP
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/lbint_ctrl.sv
module lbint_ctrl
    import lbint_pkg::*;
#(
    parameter int unsigned       NLINES   = 16,
    parameter int unsigned       ADDR_W   = 12,
    parameter int unsigned       DATA_W   = 16,
    parameter logic [NLINES-1:0] MASK_RST = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_lines,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(OFS_CODE);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

    logic [NLINES-1:0] src_q;
    logic [NLINES-1:0] mask_q;
    logic [NLINES-1:0] mask_nxt;
    logic [NLINES-1:0] pend_q;
    logic [DATA_W-1:0] src_code;
    logic              mask_load;
    logic              any_pend_nxt;

    assign mask_load = wr_en && (addr == A_MASK);

    lbint_src_reg #(.NLINES(NLINES)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_lines),
        .src_q   (src_q)
    );

    lbint_mask_reg #(.NLINES(NLINES), .MASK_RST(MASK_RST)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (mask_load),
        .data_i   (wdata[NLINES-1:0]),
        .mask_q   (mask_q),
        .mask_nxt (mask_nxt)
    );

    assign pend_q       = src_q & mask_q;
    assign any_pend_nxt = |(irq_lines & mask_nxt);

    lbint_prio_enc #(.NLINES(NLINES), .DATA_W(DATA_W)) u_enc (
        .pend_i (pend_q),
        .code_o (src_code)
    );

    lbint_irq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_pend_nxt (any_pend_nxt),
        .irq_o        (irq_o)
    );

    always_comb begin
        unique case (addr)
            A_CODE:  rdata = src_code;
            A_MASK:  rdata = DATA_W'(mask_q);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/lbint_ctrl_checker.sv
module lbint_ctrl_checker #(
    parameter int unsigned NLINES = 16,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLINES-1:0] irq_lines,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq_o,
    input logic [NLINES-1:0] src_q,
    input logic [NLINES-1:0] mask_q,
    input logic [DATA_W-1:0] src_code
);

    logic [NLINES-1:0] pend;
    logic [DATA_W-1:0] idx;
    logic              code_ok;

    always_comb begin
        pend    = src_q & mask_q;
        idx     = src_code >> 2;
        code_ok = 1'b0;
        if (src_code[1:0] == 2'b00 && idx >= 1 && idx <= NLINES) begin
            code_ok = pend[idx-1] &&
                      ((pend & ((NLINES'(1) << (idx - 1)) - NLINES'(1))) == '0);
        end
    end

    // R1: source follows the lines with one edge delay
    a_r1_src_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> src_q == $past(irq_lines));

    // R2: output agrees with the pending set held in the registers
    a_r2_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|pend));

    // R3, R8: encoded value names the lowest pending enabled line
    a_r3_code_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> code_ok);

    a_r3_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |-> src_code == '0);

    // R4: mask write lands on the next edge
    a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(2)) |=> mask_q == $past(wdata[NLINES-1:0]));

    // R6, R7: writes elsewhere leave the mask alone
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != ADDR_W'(2)) |=> $stable(mask_q));

endmodule

bind lbint_ctrl lbint_ctrl_checker #(
    .NLINES (NLINES),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq_o     (irq_o),
    .src_q     (src_q),
    .mask_q    (mask_q),
    .src_code  (src_code)
);

// File: tb/lbint_ctrl_test.sv
`timescale 1ns/1ps
module lbint_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] m_src  = '0;
    logic [15:0] m_mask = 16'h0010;

    always #2 clk = ~clk;

    lbint_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_o     (irq_o)
    );

    function automatic logic [15:0] exp_code(input logic [15:0] s, input logic [15:0] m);
        logic [15:0] p = s & m;
        for (int i = 0; i < 16; i++) begin
            if (p[i]) return 16'((i + 1) << 2);
        end
        return 16'h0000;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, update the model after the rising edge
    task automatic cycle(input logic [15:0] lines, input logic we,
                         input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        irq_lines = lines;
        wr_en     = we;
        addr      = a;
        wdata     = d;
        @(posedge clk);
        #0.5;
        m_src = lines;
        if (we && a == 12'h002) m_mask = d;
        wr_en = 1'b0;
    endtask

    // Check all observable state between edges
    task automatic observe(input string req);
        check({req, " irq"}, {15'd0, irq_o}, {15'd0, |(m_src & m_mask)});
        addr = 12'h000; #0.2;
        check({req, " code"}, rdata, exp_code(m_src, m_mask));
        addr = 12'h002; #0.2;
        check({req, " mask"}, rdata, m_mask);
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h1234_5678));
        #9 rst_n = 1'b1;
        #1;
        // R5: reset state
        addr = 12'h000; #0.2;
        check("R5 code", rdata, 16'h0000);
        addr = 12'h002; #0.2;
        check("R5 mask", rdata, 16'h0010);
        check("R5 irq", {15'd0, irq_o}, 16'h0000);

        // R1, R2: line 4 enabled by reset mask, then released
        cycle(16'h0010, 1'b0, 12'h000, 16'h0);
        observe("R2 line4 up");
        check("R3 line4 code", exp_code(m_src, m_mask), 16'h0014);
        cycle(16'h0000, 1'b0, 12'h000, 16'h0);
        observe("R1 line4 low");

        // R4: open all lines, R3 extremes
        cycle(16'h0000, 1'b1, 12'h002, 16'hFFFF);
        observe("R4 mask all");
        cycle(16'h8000, 1'b0, 12'h000, 16'h0);
        observe("R3 line15");
        addr = 12'h000; #0.2;
        check("R3 line15 value", rdata, 16'h0040);
        cycle(16'h8001, 1'b0, 12'h000, 16'h0);
        addr = 12'h000; #0.2;
        check("R3 line0 value", rdata, 16'h0004);

        // R8: masked low line hides nothing and raises nothing
        cycle(16'h8001, 1'b1, 12'h002, 16'hFFFE);
        observe("R8 masked line0");
        addr = 12'h000; #0.2;
        check("R8 line15 value", rdata, 16'h0040);
        cycle(16'h0001, 1'b0, 12'h000, 16'h0);
        observe("R8 only masked");
        check("R8 irq low", {15'd0, irq_o}, 16'h0000);

        // R6: write to code offset
        cycle(16'h0004, 1'b1, 12'h000, 16'h0000);
        observe("R6 write code");
        // R7: write to unused offsets and read them
        cycle(16'h0004, 1'b1, 12'h004, 16'h0000);
        observe("R7 write other");
        cycle(16'h0004, 1'b1, 12'h003, 16'h0000);
        observe("R7 write odd");
        addr = 12'h006; #0.2;
        check("R7 read other", rdata, 16'h0000);

        // Random phase: R1 R2 R3 R4 R6 R7 R8
        for (int k = 0; k < 600; k++) begin
            logic [15:0] ln;
            logic [11:0] a;
            int sel = $urandom_range(0, 9);
            ln = 16'($urandom);
            if ($urandom_range(0, 2) == 0) ln = ln & 16'($urandom) & 16'($urandom);
            case (sel)
                0, 1, 2: a = 12'h002;
                3:       a = 12'h000;
                4:       a = 12'($urandom);
                default: a = 12'h000;
            endcase
            cycle(ln, (sel <= 4), a, 16'($urandom));
            observe("R2 R3 R4 random");
            addr = 12'($urandom_range(4, 4095)); #0.2;
            check("R7 random read", rdata, 16'h0000);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule